// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block is the presentation stage that sits between a set of interrupt source controllers and one processor. It holds one pending interrupt at a time. Each pending interrupt has a source number, a priority and, when it came from a source controller, the index of that controller. A lower priority number is more favoured. Source controllers offer interrupts with their number, priority and controller index. The block either latches an offer or bounces it back. When a more favoured offer wins against a pending one, the displaced interrupt is returned to its owner. The interrupt line to the processor is high while something is pending.

The processor works the block through single-cycle operations. These are: setting its current priority, setting the software-interrupt (IPI) request priority, accepting the pending interrupt, polling, and signalling end of interrupt. A software interrupt is injected under a reserved source number whenever the IPI request priority is more favoured than the current priority. When the block runs out of pending work and the processor lowers its guard, it broadcasts a resend request so that sources can offer again. End-of-interrupt numbers are forwarded to the sources.

Every result is registered: every output changes on the clock edge after the inputs that cause it.

Top module: `ipc_presenter`

## Requirements
- R1: The 32-bit presentation word has the current priority in bits 31:24 and the pending source number in bits 23:0; a source number of 0 means nothing is pending. Operation codes on `op_code`: 1 = set current priority from `op_data[7:0]`, 2 = set IPI priority from `op_data[7:0]`, 3 = accept, 4 = poll, 5 = end of interrupt. Any other code has no effect.
- R2: After reset the presentation word is 0, the pending and IPI priorities are 0xFF, and `irq_out` is low.
- R3: An offer is bounced on `bounce_*` with its own number and controller index, leaving state unchanged, if its priority is greater than or equal to the current priority, or if an interrupt is pending with a priority less than or equal to the offered one.
- R4: An offer that is not bounced is latched as the pending interrupt, its controller is recorded as owner, and `irq_out` rises. If a pending interrupt had an owner, that interrupt is returned on `drop_*` in the same cycle. A pending interrupt without an owner (a software interrupt) is replaced silently.
- R5: Accept returns the old presentation word on `resp_data` with `resp_valid`. It lowers `irq_out`, moves the pending priority into the current priority, clears the source number, sets the pending priority to 0xFF and forgets the owner.
- R6: Writing an IPI priority below the current priority injects source number `IPI_NUM` with that priority and raises `irq_out`, unless a pending interrupt has a priority less than or equal to the new value. Any owned interrupt it replaces is returned on `drop_*`.
- R7: Writing a lower current priority while an interrupt is pending with a priority greater than or equal to the new value cancels it. The source number clears, the pending priority becomes 0xFF, `irq_out` falls, and the interrupt is returned on `drop_*` if it has an owner.
- R8: Writing an equal or higher current priority, or ending an interrupt, while nothing is pending raises `resend_pulse` for one cycle. In the same step, a software interrupt is injected if the IPI priority is below the new current priority.
- R9: End of interrupt loads `op_data[31:24]` into the current priority and raises `eoi_valid` for one cycle with `eoi_num` equal to `op_data[23:0]`.
- R10: An offer arriving in the same cycle as an operation is always bounced; only the operation acts on state.
- R11: Poll returns the presentation word on `resp_data` and the IPI priority on `resp_ipi`, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | A source controller offers an interrupt this cycle |
| offer_num | input | NUM_W | Offered source number |
| offer_prio | input | PRIO_W | Offered priority |
| offer_src | input | SRC_W | Index of the offering source controller |
| op_valid | input | 1 | Processor operation this cycle |
| op_code | input | 3 | Operation code (see R1) |
| op_data | input | PRIO_W+NUM_W | Operation operand |
| irq_out | output | 1 | Interrupt line to the processor |
| resp_valid | output | 1 | Response to accept or poll |
| resp_data | output | PRIO_W+NUM_W | Presentation word returned |
| resp_ipi | output | PRIO_W | IPI priority returned |
| bounce_valid | output | 1 | Incoming offer refused |
| bounce_num | output | NUM_W | Number of the refused offer |
| bounce_src | output | SRC_W | Controller of the refused offer |
| drop_valid | output | 1 | Pending interrupt handed back to its owner |
| drop_num | output | NUM_W | Number handed back |
| drop_src | output | SRC_W | Owner controller index |
| resend_pulse | output | 1 | Request to all sources to offer again |
| eoi_valid | output | 1 | End of interrupt forwarded to sources |
| eoi_num | output | NUM_W | Number whose handling ended |

## Verification
A corrupted pending number or priority shows at the next poll or accept as a wrong presentation word. It also shows at the next offer: an offer is bounced or latched against the wrong reference. A lost owner shows as a missing or misdirected hand-back on the next displacement or cancel. Because every output is registered, a wrong decision appears one clock after the stimulus. The reference model is compared on every cycle, so divergence is reported in the cycle it occurs.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_CPPR = 3'd1,
    OP_SET_IPI  = 3'd2,
    OP_ACCEPT   = 3'd3,
    OP_POLL     = 3'd4,
    OP_EOI      = 3'd5
  } ipc_op_e;

  localparam int unsigned DEF_PRIO_W = 8;
  localparam int unsigned DEF_NUM_W  = 24;
endpackage

// File: rtl/ipc_offer_eval.sv
`timescale 1ns/1ps
// Decides whether an incoming offer beats the current guard and the pending one.
module ipc_offer_eval #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              has_pend,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              wins
);
  logic below_guard;
  logic beats_pend;

  always_comb begin
    below_guard = offer_prio < cur_prio;
    beats_pend  = !has_pend || (offer_prio < pend_prio);
    wins        = below_guard && beats_pend;
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
`timescale 1ns/1ps
// Decides whether a software interrupt at a given priority may take the slot.
module ipc_ipi_eval #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              has_pend,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              inject
);
  logic pend_holds;

  always_comb begin
    pend_holds = has_pend && (pend_prio <= ipi_prio);
    inject     = (ipi_prio < cur_prio) && !pend_holds;
  end
endmodule

// File: rtl/ipc_presenter.sv
`timescale 1ns/1ps
module ipc_presenter #(
  parameter int unsigned PRIO_W  = ipc_pkg::DEF_PRIO_W,
  parameter int unsigned NUM_W   = ipc_pkg::DEF_NUM_W,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned IPI_NUM = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  input  logic [NUM_W-1:0]        offer_num,
  input  logic [PRIO_W-1:0]       offer_prio,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [PRIO_W+NUM_W-1:0] op_data,
  output logic                    irq_out,
  output logic                    resp_valid,
  output logic [PRIO_W+NUM_W-1:0] resp_data,
  output logic [PRIO_W-1:0]       resp_ipi,
  output logic                    bounce_valid,
  output logic [NUM_W-1:0]        bounce_num,
  output logic [SRC_W-1:0]        bounce_src,
  output logic                    drop_valid,
  output logic [NUM_W-1:0]        drop_num,
  output logic [SRC_W-1:0]        drop_src,
  output logic                    resend_pulse,
  output logic                    eoi_valid,
  output logic [NUM_W-1:0]        eoi_num
);
  import ipc_pkg::*;

  localparam int unsigned WORD_W = PRIO_W + NUM_W;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [NUM_W-1:0]  IPI_ID    = NUM_W'(IPI_NUM);

  // architectural state
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [NUM_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pprio_q, pprio_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              own_v_q, own_v_d;
  logic [SRC_W-1:0]  own_idx_q, own_idx_d;
  logic              irq_q, irq_d;
  logic              state_en;

  // registered outputs, next values
  logic              resp_v_d;
  logic [WORD_W-1:0] resp_data_d;
  logic [PRIO_W-1:0] resp_ipi_d;
  logic              bounce_v_d;
  logic [NUM_W-1:0]  bounce_num_d;
  logic [SRC_W-1:0]  bounce_src_d;
  logic              drop_v_d;
  logic [NUM_W-1:0]  drop_num_d;
  logic [SRC_W-1:0]  drop_src_d;
  logic              resend_d;
  logic              eoi_v_d;
  logic [NUM_W-1:0]  eoi_num_d;

  logic              has_pend;
  logic [PRIO_W-1:0] op_prio;
  logic [PRIO_W-1:0] op_hi;
  logic              offer_wins;
  logic              ipi_inject;
  logic              do_resend;
  logic [PRIO_W-1:0] resend_guard;

  assign has_pend = (xisr_q != '0);
  assign op_prio  = op_data[PRIO_W-1:0];
  assign op_hi    = op_data[WORD_W-1:NUM_W];
  assign state_en = op_valid || offer_valid;

  ipc_offer_eval #(.PRIO_W(PRIO_W)) u_offer (
    .offer_prio (offer_prio),
    .cur_prio   (cppr_q),
    .has_pend   (has_pend),
    .pend_prio  (pprio_q),
    .wins       (offer_wins)
  );

  ipc_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
    .ipi_prio   (op_prio),
    .cur_prio   (cppr_q),
    .has_pend   (has_pend),
    .pend_prio  (pprio_q),
    .inject     (ipi_inject)
  );

  // next-state process
  always_comb begin
    cppr_d       = cppr_q;
    xisr_d       = xisr_q;
    pprio_d      = pprio_q;
    mfrr_d       = mfrr_q;
    own_v_d      = own_v_q;
    own_idx_d    = own_idx_q;
    irq_d        = irq_q;
    resp_v_d     = 1'b0;
    resp_data_d  = {cppr_q, xisr_q};
    resp_ipi_d   = mfrr_q;
    bounce_v_d   = 1'b0;
    bounce_num_d = offer_num;
    bounce_src_d = offer_src;
    drop_v_d     = 1'b0;
    drop_num_d   = xisr_q;
    drop_src_d   = own_idx_q;
    resend_d     = 1'b0;
    eoi_v_d      = 1'b0;
    eoi_num_d    = op_data[NUM_W-1:0];
    do_resend    = 1'b0;
    resend_guard = cppr_q;

    if (op_valid) begin
      bounce_v_d = offer_valid;
      case (op_code)
        OP_SET_CPPR: begin
          cppr_d = op_prio;
          if (op_prio < cppr_q) begin
            if (has_pend && (op_prio <= pprio_q)) begin
              drop_v_d = own_v_q;
              xisr_d   = '0;
              pprio_d  = PRIO_IDLE;
              own_v_d  = 1'b0;
              irq_d    = 1'b0;
            end
          end else if (!has_pend) begin
            do_resend    = 1'b1;
            resend_guard = op_prio;
          end
        end
        OP_SET_IPI: begin
          mfrr_d = op_prio;
          if (ipi_inject) begin
            drop_v_d = has_pend && own_v_q;
            xisr_d   = IPI_ID;
            pprio_d  = op_prio;
            own_v_d  = 1'b0;
            irq_d    = 1'b1;
          end
        end
        OP_ACCEPT: begin
          resp_v_d = 1'b1;
          irq_d    = 1'b0;
          cppr_d   = pprio_q;
          xisr_d   = '0;
          pprio_d  = PRIO_IDLE;
          own_v_d  = 1'b0;
        end
        OP_POLL: begin
          resp_v_d = 1'b1;
        end
        OP_EOI: begin
          cppr_d  = op_hi;
          eoi_v_d = 1'b1;
          if (!has_pend) begin
            do_resend    = 1'b1;
            resend_guard = op_hi;
          end
        end
        default: begin
        end
      endcase
    end else if (offer_valid) begin
      if (offer_wins) begin
        drop_v_d  = has_pend && own_v_q;
        xisr_d    = offer_num;
        pprio_d   = offer_prio;
        own_v_d   = 1'b1;
        own_idx_d = offer_src;
        irq_d     = 1'b1;
      end else begin
        bounce_v_d = 1'b1;
      end
    end

    // resend only happens with an empty slot, so no hand-back is needed here
    if (do_resend) begin
      resend_d = 1'b1;
      if (mfrr_q < resend_guard) begin
        xisr_d  = IPI_ID;
        pprio_d = mfrr_q;
        own_v_d = 1'b0;
        irq_d   = 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q    <= '0;
      xisr_q    <= '0;
      pprio_q   <= PRIO_IDLE;
      mfrr_q    <= PRIO_IDLE;
      own_v_q   <= 1'b0;
      own_idx_q <= '0;
      irq_q     <= 1'b0;
    end else if (state_en) begin
      cppr_q    <= cppr_d;
      xisr_q    <= xisr_d;
      pprio_q   <= pprio_d;
      mfrr_q    <= mfrr_d;
      own_v_q   <= own_v_d;
      own_idx_q <= own_idx_d;
      irq_q     <= irq_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_data    <= '0;
      resp_ipi     <= '0;
      bounce_valid <= 1'b0;
      bounce_num   <= '0;
      bounce_src   <= '0;
      drop_valid   <= 1'b0;
      drop_num     <= '0;
      drop_src     <= '0;
      resend_pulse <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_num      <= '0;
    end else begin
      resp_valid   <= resp_v_d;
      resp_data    <= resp_data_d;
      resp_ipi     <= resp_ipi_d;
      bounce_valid <= bounce_v_d;
      bounce_num   <= bounce_num_d;
      bounce_src   <= bounce_src_d;
      drop_valid   <= drop_v_d;
      drop_num     <= drop_num_d;
      drop_src     <= drop_src_d;
      resend_pulse <= resend_d;
      eoi_valid    <= eoi_v_d;
      eoi_num      <= eoi_num_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/ipc_presenter_chk.sv
`timescale 1ns/1ps
module ipc_presenter_chk #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned NUM_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              offer_valid,
  input logic [PRIO_W-1:0] offer_prio,
  input logic [PRIO_W-1:0] cppr,
  input logic [NUM_W-1:0]  xisr,
  input logic [PRIO_W-1:0] pprio,
  input logic [PRIO_W-1:0] mfrr,
  input logic              irq_out,
  input logic              bounce_valid
);
  import ipc_pkg::*;

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ACCEPT) |=> (!irq_out && xisr == '0)); // R5

  AST_COLLIDE_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && offer_valid) |=> bounce_valid); // R10

  AST_WEAK_OFFER_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !op_valid && offer_prio >= cppr) |=> (bounce_valid && $stable(xisr))); // R3

  AST_POLL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_POLL) |=> ($stable(cppr) && $stable(xisr) && $stable(mfrr) && $stable(irq_out))); // R11

  AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (xisr != '0)); // R4

  AST_EMPTY_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xisr == '0) |-> (pprio == '1 && !irq_out)); // R7
endmodule

bind ipc_presenter ipc_presenter_chk #(.PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .offer_valid  (offer_valid),
  .offer_prio   (offer_prio),
  .cppr         (cppr_q),
  .xisr         (xisr_q),
  .pprio        (pprio_q),
  .mfrr         (mfrr_q),
  .irq_out      (irq_out),
  .bounce_valid (bounce_valid)
);

// File: tb/sim_ipc_presenter.sv
`timescale 1ns/1ps
module sim_ipc_presenter;
  logic        clk;
  logic        rst_n;
  logic        offer_valid;
  logic [23:0] offer_num;
  logic [7:0]  offer_prio;
  logic [1:0]  offer_src;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_data;
  logic        irq_out, resp_valid, bounce_valid, drop_valid, resend_pulse, eoi_valid;
  logic [31:0] resp_data;
  logic [7:0]  resp_ipi;
  logic [23:0] bounce_num, drop_num, eoi_num;
  logic [1:0]  bounce_src, drop_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ipc_presenter u0 (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_num(offer_num), .offer_prio(offer_prio), .offer_src(offer_src),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .irq_out(irq_out), .resp_valid(resp_valid), .resp_data(resp_data), .resp_ipi(resp_ipi),
    .bounce_valid(bounce_valid), .bounce_num(bounce_num), .bounce_src(bounce_src),
    .drop_valid(drop_valid), .drop_num(drop_num), .drop_src(drop_src),
    .resend_pulse(resend_pulse), .eoi_valid(eoi_valid), .eoi_num(eoi_num)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cppr, m_xisr, m_pp, m_mfrr, m_own;
  bit m_ownv, m_irq;
  bit m_rv, m_bv, m_dv, m_rs, m_ev;
  int m_resp, m_ripi, m_bn, m_bs, m_dn, m_ds, m_en;
  localparam int IPI = 2;

  task automatic m_handback();
    if (m_ownv) begin m_dv = 1; m_dn = m_xisr; m_ds = m_own; end
  endtask

  task automatic m_resend();
    m_rs = 1;
    if (m_mfrr < m_cppr) begin
      m_xisr = IPI; m_pp = m_mfrr; m_ownv = 0; m_irq = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cppr = 0; m_xisr = 0; m_pp = 255; m_mfrr = 255; m_ownv = 0; m_own = 0; m_irq = 0;
      m_rv = 0; m_bv = 0; m_dv = 0; m_rs = 0; m_ev = 0;
    end else begin
      m_rv = 0; m_bv = 0; m_dv = 0; m_rs = 0; m_ev = 0;
      if (op_valid) begin
        int v;
        int old;
        v = int'(op_data[7:0]);
        if (offer_valid) begin m_bv = 1; m_bn = offer_num; m_bs = offer_src; end
        case (int'(op_code))
          1: begin
            old = m_cppr; m_cppr = v;
            if (v < old) begin
              if (m_xisr != 0 && v <= m_pp) begin
                m_handback();
                m_xisr = 0; m_pp = 255; m_ownv = 0; m_irq = 0;
              end
            end else if (m_xisr == 0) m_resend();
          end
          2: begin
            m_mfrr = v;
            if (v < m_cppr && !(m_xisr != 0 && m_pp <= v)) begin
              if (m_xisr != 0) m_handback();
              m_xisr = IPI; m_pp = v; m_ownv = 0; m_irq = 1;
            end
          end
          3: begin
            m_rv = 1; m_resp = (m_cppr << 24) | m_xisr; m_ripi = m_mfrr;
            m_irq = 0; m_cppr = m_pp; m_xisr = 0; m_pp = 255; m_ownv = 0;
          end
          4: begin
            m_rv = 1; m_resp = (m_cppr << 24) | m_xisr; m_ripi = m_mfrr;
          end
          5: begin
            m_cppr = int'(op_data[31:24]);
            m_ev = 1; m_en = int'(op_data[23:0]);
            if (m_xisr == 0) m_resend();
          end
          default: ;
        endcase
      end else if (offer_valid) begin
        if (int'(offer_prio) >= m_cppr || (m_xisr != 0 && m_pp <= int'(offer_prio))) begin
          m_bv = 1; m_bn = offer_num; m_bs = offer_src;
        end else begin
          if (m_xisr != 0) m_handback();
          m_xisr = offer_num; m_pp = offer_prio; m_own = offer_src; m_ownv = 1; m_irq = 1;
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 model irq_out", {31'd0, irq_out}, {31'd0, m_irq});
      check("R3 model bounce_valid", {31'd0, bounce_valid}, {31'd0, m_bv});
      if (m_bv) begin
        check("R3 model bounce_num", {8'd0, bounce_num}, m_bn);
        check("R3 model bounce_src", {30'd0, bounce_src}, m_bs);
      end
      check("R4 model drop_valid", {31'd0, drop_valid}, {31'd0, m_dv});
      if (m_dv) begin
        check("R4 model drop_num", {8'd0, drop_num}, m_dn);
        check("R4 model drop_src", {30'd0, drop_src}, m_ds);
      end
      check("R8 model resend_pulse", {31'd0, resend_pulse}, {31'd0, m_rs});
      check("R9 model eoi_valid", {31'd0, eoi_valid}, {31'd0, m_ev});
      if (m_ev) check("R9 model eoi_num", {8'd0, eoi_num}, m_en);
      check("R5 model resp_valid", {31'd0, resp_valid}, {31'd0, m_rv});
      if (m_rv) begin
        check("R5 model resp_data", resp_data, m_resp);
        check("R11 model resp_ipi", {24'd0, resp_ipi}, m_ripi);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle();
    op_valid = 0; offer_valid = 0; op_code = 0; op_data = 0;
    offer_num = 0; offer_prio = 0; offer_src = 0;
  endtask

  task automatic do_op(int code, logic [31:0] data);
    @(negedge clk);
    op_valid = 1; op_code = 3'(code); op_data = data;
    @(negedge clk);
    idle();
  endtask

  task automatic do_offer(logic [23:0] num, logic [7:0] prio, logic [1:0] src);
    @(negedge clk);
    offer_valid = 1; offer_num = num; offer_prio = prio; offer_src = src;
    @(negedge clk);
    idle();
  endtask

  task automatic do_both(int code, logic [31:0] data, logic [23:0] num, logic [7:0] prio, logic [1:0] src);
    @(negedge clk);
    op_valid = 1; op_code = 3'(code); op_data = data;
    offer_valid = 1; offer_num = num; offer_prio = prio; offer_src = src;
    @(negedge clk);
    idle();
  endtask

  task automatic poll_expect(string tag, logic [31:0] word);
    do_op(4, 0);
    check(tag, resp_data, word);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    check("R2 reset irq_out", {31'd0, irq_out}, 0);
    do_op(4, 0);
    check("R2 reset word", resp_data, 32'h0);
    check("R2 reset ipi prio", {24'd0, resp_ipi}, 32'hFF);

    do_offer(24'h10, 8'd5, 2'd1);       // guard 0: every offer bounced
    check("R3 bounce at guard 0", {31'd0, bounce_valid}, 1);
    check("R3 bounce num", {8'd0, bounce_num}, 32'h10);

    do_op(1, 32'hFF);                   // raise guard with empty slot
    check("R8 resend on guard raise", {31'd0, resend_pulse}, 1);
    check("R8 no ipi when ipi prio idle", {31'd0, irq_out}, 0);

    do_offer(24'h10, 8'd5, 2'd1);
    check("R4 offer latched", {31'd0, irq_out}, 1);
    do_offer(24'h20, 8'd5, 2'd2);
    check("R3 equal priority bounced", {31'd0, bounce_valid}, 1);
    do_offer(24'h30, 8'd3, 2'd3);
    check("R4 displaced handed back", {31'd0, drop_valid}, 1);
    check("R4 displaced num", {8'd0, drop_num}, 32'h10);
    check("R4 displaced owner", {30'd0, drop_src}, 1);
    poll_expect("R1 word layout", 32'hFF000030);

    do_op(2, 32'd4);
    check("R6 ipi held off by pending", {31'd0, drop_valid}, 0);
    poll_expect("R6 pending kept", 32'hFF000030);
    do_op(2, 32'd1);
    check("R6 ipi displaces owned", {31'd0, drop_valid}, 1);
    check("R6 displaced num", {8'd0, drop_num}, 32'h30);
    poll_expect("R6 ipi number loaded", 32'hFF000002);
    check("R11 poll ipi prio", {24'd0, resp_ipi}, 32'd1);

    do_op(3, 0);
    check("R5 accept returns word", resp_data, 32'hFF000002);
    check("R5 accept lowers line", {31'd0, irq_out}, 0);
    poll_expect("R5 guard takes pending prio", 32'h01000000);

    do_both(4, 0, 24'h40, 8'd0, 2'd0);
    check("R10 collision bounced", {31'd0, bounce_valid}, 1);
    check("R10 collision poll word", resp_data, 32'h01000000);

    do_offer(24'h40, 8'd0, 2'd0);
    check("R4 offer below guard 1", {31'd0, irq_out}, 1);
    do_op(1, 32'd0);
    check("R7 cancel hands back", {31'd0, drop_valid}, 1);
    check("R7 cancel num", {8'd0, drop_num}, 32'h40);
    check("R7 cancel lowers line", {31'd0, irq_out}, 0);
    poll_expect("R7 slot empty", 32'h00000000);

    do_op(5, 32'hFF000002);
    check("R9 eoi forwarded", {31'd0, eoi_valid}, 1);
    check("R9 eoi num", {8'd0, eoi_num}, 32'h2);
    check("R8 resend after eoi", {31'd0, resend_pulse}, 1);
    check("R8 ipi injected on resend", {31'd0, irq_out}, 1);
    poll_expect("R9 guard from eoi", 32'hFF000002);

    do_offer(24'h50, 8'd0, 2'd2);
    check("R4 ipi replaced silently", {31'd0, drop_valid}, 0);
    poll_expect("R4 new pending", 32'hFF000050);

    do_op(6, 32'hFFFFFFFF);
    poll_expect("R1 unused code no effect", 32'hFF000050);

    // random phase, checked by the model on every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      idle();
      if (($urandom % 10) < 3) begin
        int c;
        c = 1 + ($urandom % 5);
        op_valid = 1; op_code = 3'(c);
        case (c)
          1: op_data = (($urandom % 4) == 0) ? 32'hFF : 32'($urandom % 16);
          2: op_data = (($urandom % 3) == 0) ? 32'hFF : 32'($urandom % 16);
          5: op_data = {(($urandom % 2) == 0) ? 8'hFF : 8'($urandom % 16), 24'($urandom)};
          default: op_data = $urandom;
        endcase
      end
      if (($urandom % 10) < 4) begin
        offer_valid = 1;
        offer_num = 24'h100 + 24'($urandom % 4096);
        offer_prio = 8'($urandom % 16);
        offer_src = 2'($urandom);
      end
    end
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule